// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the CPU side of a system controller and decides which target an outgoing CPU address belongs to. It holds ten programmable windows (four chip-select groups, then I/O, memory 0 and memory 1 for a first PCI port, then the same three for a second PCI port). It also holds a 4 KB window that covers the controller's own register file. Each window is placed and sized in 2 MB steps by a low and a high decode register. Each window also has a remap register that defines an alias of the same size at a different place in the top address bits.

A simple register-write port loads the decode registers. A purely combinational lookup maps a 32-bit CPU address to a winning window. The result comes out as a one-hot vector, a binary index, flags for the internal-register window and for alias hits, and, for I/O windows, the 16-bit port address. Two reserved address regions are always cut out of every programmable window and its alias. Software can therefore never overlay them.

Top module: `addr_window_decoder`

## Requirements
- R1: A write (`wr_en`=1 at a rising clock edge) selects its register with `wr_sel`. Values 0..9 select the low register of window 0..9, 10..19 select the high register of window 0..9, 20..29 select the remap register of window 0..9, and 30 selects the internal-register window base. The new value is seen by the lookup from that edge on, and not before it.
- R2: The low register keeps `wr_data[14:0]`, the high register keeps `wr_data[6:0]`, the remap register keeps `wr_data[10:0]` and the internal base keeps `wr_data[14:0]`. All other written bits are dropped.
- R3: A window starts at low[10:0] × 2 MB and spans (high + 1 − low[6:0]) × 2 MB. It only hits when low[6:0] ≤ high.
- R4: A write to a window's low register also loads that window's remap register with `wr_data[10:0]`.
- R5: The alias of a window has the primary's (clipped) length. Its start is the primary's clipped start with bits [31:21] replaced by the remap value, and it is clipped again. A disabled primary gives an empty alias.
- R6: The internal-register window covers exactly 4 KB, starting at base[10:0] × 2 MB.
- R7: A window start that lies in 0x1E000000–0x1F0FFFFF moves to 0x1F100000. A window start that lies in 0x1FC00000–0x1FCFFFFF moves to 0x1FD00000.
- R8: A window end (exclusive) that lies inside a reserved region, or that spans one from below, is pulled back to that region's start.
- R9: Windows 4 and 7 are I/O windows. A hit on one of them (primary or alias) drives `port_addr` = address[15:0]. Every other result drives 0.
- R10: The internal window wins over all others. Next come the primary windows, lowest index first, and then the aliases, lowest index first. The `hit_onehot` bit k / `hit_idx` k names the winning window. `hit_alias` marks an alias win.
- R11: A write with `wr_sel` = 31 changes no register.
- R12: After reset every programmable window is disabled (low=1, high=0, remap=0). The internal window sits at base 0x0DF, which is 0x1BE00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select (R1 encoding) |
| wr_data | input | 32 | Write data |
| lk_addr | input | 32 | CPU address to decode |
| hit | output | 1 | Any window matched |
| hit_internal | output | 1 | Internal-register window matched |
| hit_alias | output | 1 | Winning match is a remap alias |
| hit_onehot | output | 10 | One-hot winning programmable window |
| hit_idx | output | 4 | Index of winning programmable window |
| port_addr | output | 16 | I/O port address on an I/O window hit |

## Verification
The assertions assume that `wr_sel` and `wr_data` are driven to known values whenever `wr_en` is high. They also assume that `lk_addr` is stable around the sampling edge. The bench drives every input at the falling edge and holds it for a full cycle, so both conditions hold. The stimulus always writes a window's low register before its high register. This keeps a freshly programmed high bound from briefly opening a huge window over the reset low value of 1, which would mask the priority cases.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int NUM_WIN  = 10;
  localparam int GRAN_SH  = 21;
  localparam int LO_W     = 15;
  localparam int HI_W     = 7;
  localparam int RM_W     = 11;
  localparam int AW       = 32;
  localparam int XW       = AW + 1;
  localparam int NREG     = 3 * NUM_WIN + 1;
  localparam int SEL_W    = $clog2(NREG);
  localparam int IDX_W    = $clog2(NUM_WIN);
  localparam int PORT_W   = 16;
  localparam int INT_SZ   = 4096;
  localparam logic [NUM_WIN-1:0] IO_MASK = 10'b00_1001_0000;

  localparam logic [LO_W-1:0] LO_RST  = 15'h0001;
  localparam logic [HI_W-1:0] HI_RST  = 7'h00;
  localparam logic [RM_W-1:0] RM_RST  = 11'h000;
  localparam logic [LO_W-1:0] INT_RST = 15'h00DF;

  localparam logic [XW-1:0] RSVA_LO = 33'h01E000000;
  localparam logic [XW-1:0] RSVA_HI = 33'h01F100000;
  localparam logic [XW-1:0] RSVB_LO = 33'h01FC00000;
  localparam logic [XW-1:0] RSVB_HI = 33'h01FD00000;

  typedef struct packed {
    logic [XW-1:0] b;
    logic [XW-1:0] e;
  } span_t;

  // Cut both reserved regions out of [b, e); steps are applied in sequence.
  function automatic span_t clip_span(input logic [XW-1:0] b_in,
                                      input logic [XW-1:0] e_in);
    span_t s;
    s.b = b_in;
    s.e = e_in;
    if (s.e >= RSVA_LO && s.e < RSVA_HI) s.e = RSVA_LO;
    if (s.b >= RSVA_LO && s.b < RSVA_HI) s.b = RSVA_HI;
    if (s.e >= RSVB_LO && s.e < RSVB_HI) s.e = RSVB_LO;
    if (s.b >= RSVB_LO && s.b < RSVB_HI) s.b = RSVB_HI;
    if (s.e >= RSVA_HI && s.b < RSVA_LO) s.e = RSVA_LO;
    if (s.e >= RSVB_HI && s.b < RSVB_LO) s.e = RSVB_LO;
    return s;
  endfunction
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]    wr_data,
  output logic [LO_W-1:0]  lo_q [NUM_WIN],
  output logic [HI_W-1:0]  hi_q [NUM_WIN],
  output logic [RM_W-1:0]  rm_q [NUM_WIN],
  output logic [LO_W-1:0]  int_q
);
  localparam int HI_OFS = NUM_WIN;
  localparam int RM_OFS = 2 * NUM_WIN;
  localparam int INT_SEL = 3 * NUM_WIN;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    logic lo_we, hi_we, rm_we;
    assign lo_we = wr_en && (wr_sel == SEL_W'(k));
    assign hi_we = wr_en && (wr_sel == SEL_W'(HI_OFS + k));
    assign rm_we = wr_en && (wr_sel == SEL_W'(RM_OFS + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[k] <= LO_RST;
        hi_q[k] <= HI_RST;
        rm_q[k] <= RM_RST;
      end else begin
        if (lo_we) lo_q[k] <= wr_data[LO_W-1:0];
        if (hi_we) hi_q[k] <= wr_data[HI_W-1:0];
        if (lo_we || rm_we) rm_q[k] <= wr_data[RM_W-1:0];
      end
    end

    a_r4_low_loads_remap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(k)) |=> (rm_q[k] == $past(wr_data[RM_W-1:0])));
    a_r2_high_trunc: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(HI_OFS + k)) |=> (hi_q[k] == $past(wr_data[HI_W-1:0])));
    a_r11_ignored_win: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel >= SEL_W'(NREG)) |=> ($stable(lo_q[k]) && $stable(hi_q[k]) && $stable(rm_q[k])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= INT_RST;
    else if (wr_en && wr_sel == SEL_W'(INT_SEL)) int_q <= wr_data[LO_W-1:0];
  end

  a_r11_ignored_int: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel >= SEL_W'(NREG)) |=> $stable(int_q));
endmodule

// File: rtl/awd_span.sv
module awd_span
  import awd_pkg::*;
(
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  input  logic [RM_W-1:0] rm,
  input  logic [AW-1:0]   addr,
  output logic            prim_hit,
  output logic            alias_hit
);
  localparam int BASE_W = AW - GRAN_SH;

  logic              en;
  logic [HI_W:0]     units;
  logic [XW-1:0]     pb, pe, plen, ab, ae, ax;
  span_t             ps, as;

  assign en    = (lo[HI_W-1:0] <= hi);
  assign units = ({1'b0, hi} + 1'b1) - {1'b0, lo[HI_W-1:0]};
  assign pb    = {1'b0, lo[BASE_W-1:0], {GRAN_SH{1'b0}}};
  assign pe    = en ? pb + {{(XW-HI_W-1-GRAN_SH){1'b0}}, units, {GRAN_SH{1'b0}}} : pb;
  assign ps    = clip_span(pb, pe);
  assign plen  = (ps.e > ps.b) ? ps.e - ps.b : '0;
  assign ab    = {1'b0, rm, ps.b[GRAN_SH-1:0]};
  assign ae    = ab + plen;
  assign as    = clip_span(ab, ae);
  assign ax    = {1'b0, addr};

  assign prim_hit  = en && (ax >= ps.b) && (ax < ps.e);
  assign alias_hit = en && (ax >= as.b) && (ax < as.e);
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [AW-1:0]       wr_data,
  input  logic [AW-1:0]       lk_addr,
  output logic                hit,
  output logic                hit_internal,
  output logic                hit_alias,
  output logic [NUM_WIN-1:0]  hit_onehot,
  output logic [IDX_W-1:0]    hit_idx,
  output logic [PORT_W-1:0]   port_addr
);
  localparam int BASE_W = AW - GRAN_SH;

  logic [LO_W-1:0]    lo_q [NUM_WIN];
  logic [HI_W-1:0]    hi_q [NUM_WIN];
  logic [RM_W-1:0]    rm_q [NUM_WIN];
  logic [LO_W-1:0]    int_q;
  logic [NUM_WIN-1:0] p_hit, a_hit;
  logic [XW-1:0]      int_b, ax;

  awd_regfile u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .lo_q, .hi_q, .rm_q, .int_q
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_span
    awd_span u_span (
      .lo(lo_q[k]), .hi(hi_q[k]), .rm(rm_q[k]), .addr(lk_addr),
      .prim_hit(p_hit[k]), .alias_hit(a_hit[k])
    );
  end

  assign int_b        = {1'b0, int_q[BASE_W-1:0], {GRAN_SH{1'b0}}};
  assign ax           = {1'b0, lk_addr};
  assign hit_internal = (ax >= int_b) && (ax < int_b + XW'(INT_SZ));

  always_comb begin
    logic found;
    found      = 1'b0;
    hit_alias  = 1'b0;
    hit_onehot = '0;
    hit_idx    = '0;
    if (!hit_internal) begin
      for (int k = 0; k < NUM_WIN; k++) begin
        if (!found && p_hit[k]) begin
          found = 1'b1;
          hit_onehot[k] = 1'b1;
          hit_idx = IDX_W'(k);
        end
      end
      for (int k = 0; k < NUM_WIN; k++) begin
        if (!found && a_hit[k]) begin
          found = 1'b1;
          hit_alias = 1'b1;
          hit_onehot[k] = 1'b1;
          hit_idx = IDX_W'(k);
        end
      end
    end
  end

  assign hit       = hit_internal || (|hit_onehot);
  assign port_addr = (|(hit_onehot & IO_MASK)) ? lk_addr[PORT_W-1:0] : '0;

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_onehot));
  a_r10_internal_first: assert property (@(posedge clk) disable iff (!rst_n)
    hit_internal |-> (hit_onehot == '0 && !hit_alias));
  a_r10_primary_before_alias: assert property (@(posedge clk) disable iff (!rst_n)
    hit_alias |-> (p_hit == '0));
  a_r9_port_only_io: assert property (@(posedge clk) disable iff (!rst_n)
    (port_addr != '0) |-> (hit && !hit_internal));
  a_r6_internal_size: assert property (@(posedge clk) disable iff (!rst_n)
    hit_internal |-> (lk_addr[AW-1:12] == int_b[AW-1:12]));
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] lk_addr = '0;
  logic        hit, hit_internal, hit_alias;
  logic [9:0]  hit_onehot;
  logic [3:0]  hit_idx;
  logic [15:0] port_addr;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_window_decoder dut (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .lk_addr,
    .hit, .hit_internal, .hit_alias, .hit_onehot, .hit_idx, .port_addr
  );

  // exp_idx < 0: no programmable window expected
  task automatic look(input logic [31:0] a, input bit e_int, input int e_idx,
                      input bit e_alias, input logic [15:0] e_port, input string tag);
    logic [9:0] e_oh;
    bit e_hit;
    lk_addr = a;
    #1;
    e_oh  = (e_idx >= 0) ? (10'b1 << e_idx) : '0;
    e_hit = e_int || (e_idx >= 0);
    n_tests++;
    if (hit !== e_hit || hit_internal !== e_int || hit_onehot !== e_oh ||
        hit_alias !== e_alias || port_addr !== e_port ||
        (e_idx >= 0 && hit_idx !== 4'(e_idx))) begin
      n_fail++;
      $display("FAIL %s addr=%h: got hit=%b int=%b oh=%b idx=%0d alias=%b port=%h exp hit=%b int=%b oh=%b idx=%0d alias=%b port=%h",
               tag, a, hit, hit_internal, hit_onehot, hit_idx, hit_alias, port_addr,
               e_hit, e_int, e_oh, e_idx, e_alias, e_port);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    look(32'h1BE00000, 1, -1, 0, 16'h0, "R12 internal at reset");
    look(32'h1BE00FFF, 1, -1, 0, 16'h0, "R6 last internal byte");
    look(32'h1BE01000, 0, -1, 0, 16'h0, "R6 past internal window");
    look(32'h00200000, 0, -1, 0, 16'h0, "R12 windows disabled");
  endtask

  task automatic t_basic();
    wr(5'd5, 32'h0000_0040);
    wr(5'd15, 32'h0000_0041);
    look(32'h083FFFFC, 0, 5, 0, 16'h0, "R3 inside window 5");
    look(32'h08400000, 0, -1, 0, 16'h0, "R3 end of window 5");
    look(32'h07FFFFFF, 0, -1, 0, 16'h0, "R3 below window 5");
    wr(5'd25, 32'hFFFF_F850);
    look(32'h0A100000, 0, 5, 1, 16'h0, "R5 alias of window 5");
    look(32'h08100000, 0, 5, 0, 16'h0, "R5 primary after remap");
    look(32'h0A400000, 0, -1, 0, 16'h0, "R5 alias length");
  endtask

  task automatic t_disabled();
    wr(5'd0, 32'h0000_0003);
    wr(5'd10, 32'h0000_0002);
    look(32'h00600000, 0, -1, 0, 16'h0, "R3 low above high disables");
    look(32'h00400000, 0, -1, 0, 16'h0, "R5 disabled alias empty");
  endtask

  task automatic t_trunc();
    wr(5'd1, 32'hFFFF_8004);
    wr(5'd11, 32'hFFFF_FF85);
    look(32'h00BFFFFF, 0, 1, 0, 16'h0, "R2 truncated fields window 1");
    look(32'h00C00000, 0, -1, 0, 16'h0, "R2 truncated high bound");
    look(32'h00900000, 0, 1, 0, 16'h0, "R4 remap equals low alias overlap");
  endtask

  task automatic t_clip_start();
    wr(5'd7, 32'h0000_00F0);
    wr(5'd17, 32'h0000_00F9);
    look(32'h1E800000, 0, -1, 0, 16'h0, "R7 reserved start skipped");
    look(32'h1F100000, 0, 7, 0, 16'h0000, "R7 new start io");
    look(32'h1F123456, 0, 7, 0, 16'h3456, "R9 io port address");
    look(32'h1F3FFFFF, 0, 7, 0, 16'hFFFF, "R9 io port top");
  endtask

  task automatic t_clip_span();
    wr(5'd2, 32'h0000_00E0);
    wr(5'd12, 32'h0000_00FF);
    look(32'h1DFFFFFF, 0, 2, 0, 16'h0, "R8 end pulled before region");
    look(32'h1FD00000, 0, -1, 0, 16'h0, "R8 nothing past region");
    look(32'h1FC00000, 0, -1, 0, 16'h0, "R8 second region untouched");
  endtask

  task automatic t_priority();
    wr(5'd3, 32'h0000_0040);
    wr(5'd13, 32'h0000_0041);
    look(32'h08001000, 0, 3, 0, 16'h0, "R10 lowest primary wins");
    wr(5'd30, 32'hFFFF_0040);
    look(32'h08000000, 1, -1, 0, 16'h0, "R10 internal wins");
    look(32'h08001000, 0, 3, 0, 16'h0, "R6 4KB internal only");
    look(32'h1BE00000, 0, -1, 0, 16'h0, "R1 internal moved");
  endtask

  task automatic t_ignored();
    wr(5'd31, 32'h0000_00DF);
    look(32'h08000000, 1, -1, 0, 16'h0, "R11 internal base unchanged");
    look(32'h08001000, 0, 3, 0, 16'h0, "R11 windows unchanged");
    look(32'h1BE00000, 0, -1, 0, 16'h0, "R11 no relocation");
  endtask

  task automatic t_timing();
    wr(5'd9, 32'h0000_0060);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 5'd19; wr_data = 32'h0000_0060;
    look(32'h0C1FFFFF, 0, -1, 0, 16'h0, "R1 before write edge");
    @(posedge clk);
    #1;
    look(32'h0C1FFFFF, 0, 9, 0, 16'h0, "R1 after write edge");
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_disabled();
    t_trunc();
    t_clip_start();
    t_clip_span();
    t_priority();
    t_ignored();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule